// File: doc/BRIEF.md
# I2C Register-Write Target

This block is an I2C target that receives write transactions and turns each complete one into a single write request for a register bank. SCL and SDA come in from the pads as raw levels. They pass through two-flop synchronizers, and the block then finds START and STOP conditions in the synchronized levels. The block answers only one fixed 7-bit device address, and only with the direction bit cleared. After that address byte it takes a 16-bit register address and then a payload of one, two or four bytes. The upper nibble of the register address sets the payload length.

The block acknowledges every byte it accepts by enabling the SDA pull-down during the ninth clock of that byte. Once the last payload byte has been acknowledged, it raises a one-cycle strobe that carries the register address, the value and a size code. If a transaction ends before all of its payload bytes arrive, the partial value is dropped. The only pad-side output is the SDA pull-down enable.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset the SDA pull-down enable `sda_oe` and the strobe `wr_stb` are both 0.
- R2: A first byte equal to the device address followed by a 0 direction bit (0x70 with the default address 0x38) is acknowledged. Any other first byte is not acknowledged, and every later byte is ignored and left unacknowledged until the next START.
- R3: Both register-address bytes (high byte first) and each expected payload byte are acknowledged. An acknowledge means `sda_oe`=1 while SCL is high during the ninth clock of the byte.
- R4: The register address selects the payload length: nibble [15:12]=0x0 gives 1 byte (size code 0), 0x1 gives 2 bytes (code 1) and 0x2 gives 4 bytes (code 2). Bytes arrive MSB first and most significant byte first. `wr_data` holds the value right-aligned and zero-extended.
- R5: `wr_stb` is high for exactly one clock per complete transaction. It rises in the cycle in which the acknowledge of the last payload byte is released, and `wr_addr`, `wr_data` and `wr_size` carry that transaction's values.
- R6: A register address whose upper nibble is 0x3 to 0xF is acknowledged, and so are the data bytes that follow it, but no strobe is produced.
- R7: A STOP or a repeated START that arrives before the last payload byte discards the partial value with no strobe. A repeated START opens a fresh transaction.
- R8: A byte sent after the last payload byte is not acknowledged and causes no further strobe.
- R9: `sda_oe` rises only while the synchronized SCL is low, and it is 0 after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from pad |
| sda_i | input | 1 | Raw SDA level from pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle register write request |
| wr_addr | output | 16 | Register address of the write |
| wr_data | output | 32 | Written value, right-aligned |
| wr_size | output | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |

## Verification
Complete writes are sent to each of the three address pages. This separates the 1-, 2- and 4-byte payload decodes, and the byte order shows up in `wr_data`. Two kinds of wrong first byte are sent: a read to the correct address and a write to a different address. They show that both the address match and the direction-bit check are in force, and a good write afterwards shows that the next START recovers the block. Further tests cover an unmapped page, a STOP in the middle of the payload, a repeated START in the middle of the payload and an extra trailing byte. These separate acknowledging a byte from committing a write, so they check that a strobe appears only for a complete, mapped transaction.

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target #(
  parameter logic [6:0] DEV_ADDR = 7'h38,
  parameter logic [3:0] PAGE_W8  = 4'h0,
  parameter logic [3:0] PAGE_W16 = 4'h1,
  parameter logic [3:0] PAGE_W32 = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic        wr_stb,
  output logic [15:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [1:0]  wr_size
);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_SKIP} st_t;

  logic [2:0]  scl_s, sda_s;
  st_t         st;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic [2:0]  byte_idx;
  logic [15:0] addr_r;
  logic [31:0] data_r;
  logic [2:0]  need;
  logic        last_r;

  wire scl_q = scl_s[1];
  wire scl_p = scl_s[2];
  wire sda_q = sda_s[1];
  wire sda_p = sda_s[2];

  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire scl_rise  = scl_q & ~scl_p;
  wire scl_fall  = ~scl_q & scl_p;

  wire [2:0] data_no = byte_idx - 3'd2;

  function automatic logic [2:0] bytes_for(input logic [15:0] a);
    if (a[15:12] == PAGE_W8)       return 3'd1;
    else if (a[15:12] == PAGE_W16) return 3'd2;
    else if (a[15:12] == PAGE_W32) return 3'd4;
    else                           return 3'd0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      addr_r   <= '0;
      data_r   <= '0;
      need     <= '0;
      last_r   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_size  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        st       <= S_RX;
        bit_cnt  <= '0;
        byte_idx <= '0;
        data_r   <= '0;
        last_r   <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        last_r <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              st      <= S_ACK;
              sda_oe  <= 1'b1;
              if (byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
              case (byte_idx)
                3'd0: if (shreg != {DEV_ADDR, 1'b0}) begin
                  st     <= S_SKIP;
                  sda_oe <= 1'b0;
                end
                3'd1: addr_r[15:8] <= shreg;
                3'd2: begin
                  addr_r[7:0] <= shreg;
                  need        <= bytes_for({addr_r[15:8], shreg});
                end
                default: if (need != 3'd0) begin
                  data_r <= {data_r[23:0], shreg};
                  last_r <= (data_no == need);
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (last_r) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr_r;
                wr_data <= data_r;
                wr_size <= (need == 3'd1) ? 2'd0 : (need == 3'd2) ? 2'd1 : 2'd2;
                last_r  <= 1'b0;
                st      <= S_SKIP;
              end else begin
                st <= S_RX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regwr_target_chk.sv
module i2c_regwr_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic wr_stb
);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r5_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> ($past(sda_oe) && !sda_oe));

  a_r9_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  a_r9_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_q);

  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

endmodule

bind i2c_regwr_target i2c_regwr_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_q    (scl_s[1]),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .wr_stb   (wr_stb)
);

// File: tb/i2c_regwr_target_bench.sv
`timescale 1ns/1ps
module i2c_regwr_target_bench;

  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  wr_size;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_err = 0;
  int stb_cycles = 0;
  logic [15:0] cap_addr;
  logic [31:0] cap_data;
  logic [1:0]  cap_size;

  always #4 clk = ~clk;

  i2c_regwr_target u_i2c_regwr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size(wr_size)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cycles <= stb_cycles + 1;
      cap_addr   <= wr_addr;
      cap_data   <= wr_data;
      cap_size   <= wr_size;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(posedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_half();
    scl_m = 1'b1; wait_half();
    sda_m = 1'b0; wait_half();
    scl_m = 1'b0; wait_half();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_half();
    scl_m = 1'b1; wait_half();
    sda_m = 1'b1; wait_half();
    wait_half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_half();
      scl_m = 1'b1; wait_half();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_half();
    scl_m = 1'b1; repeat (HALF / 2) @(posedge clk);
    @(negedge clk); acked = (sda_line == 1'b0);
    repeat (HALF / 2) @(posedge clk);
    scl_m = 1'b0; wait_half();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    chk("R1 wr_stb after reset", {31'd0, wr_stb}, 32'd0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [31:0] d, input int nb,
                         input logic [1:0] sz);
    logic ack;
    int base;
    base = stb_cycles;
    i2c_start();
    send_byte(8'h70, ack);      chk("R2 device address ack", {31'd0, ack}, 32'd1);
    send_byte(a[15:8], ack);    chk("R3 addr high ack", {31'd0, ack}, 32'd1);
    send_byte(a[7:0], ack);     chk("R3 addr low ack", {31'd0, ack}, 32'd1);
    for (int i = nb - 1; i >= 0; i--) begin
      send_byte(d[8*i +: 8], ack);
      chk("R3 data byte ack", {31'd0, ack}, 32'd1);
    end
    chk("R5 strobe before stop", stb_cycles - base, 32'd1);
    i2c_stop();
    chk("R9 released after stop", {31'd0, sda_oe}, 32'd0);
    chk("R5 single strobe cycle", stb_cycles - base, 32'd1);
    chk("R5 strobe address", {16'd0, cap_addr}, {16'd0, a});
    chk("R4 strobe data", cap_data, d);
    chk("R4 size code", {30'd0, cap_size}, {30'd0, sz});
  endtask

  task automatic t_bad_first(input logic [7:0] first);
    logic ack;
    int base;
    base = stb_cycles;
    i2c_start();
    send_byte(first, ack);  chk("R2 wrong first byte nack", {31'd0, ack}, 32'd0);
    send_byte(8'h00, ack);  chk("R2 ignored byte nack", {31'd0, ack}, 32'd0);
    send_byte(8'h12, ack);  chk("R2 ignored byte nack", {31'd0, ack}, 32'd0);
    send_byte(8'h34, ack);  chk("R2 ignored byte nack", {31'd0, ack}, 32'd0);
    i2c_stop();
    chk("R2 no strobe on foreign address", stb_cycles - base, 32'd0);
  endtask

  task automatic t_unmapped();
    logic ack;
    int base;
    base = stb_cycles;
    i2c_start();
    send_byte(8'h70, ack);
    send_byte(8'h50, ack);  chk("R6 unmapped addr high ack", {31'd0, ack}, 32'd1);
    send_byte(8'h00, ack);  chk("R6 unmapped addr low ack", {31'd0, ack}, 32'd1);
    send_byte(8'hAB, ack);  chk("R6 unmapped data ack", {31'd0, ack}, 32'd1);
    send_byte(8'hCD, ack);  chk("R6 unmapped data ack", {31'd0, ack}, 32'd1);
    i2c_stop();
    chk("R6 no strobe for unmapped", stb_cycles - base, 32'd0);
  endtask

  task automatic t_early_stop();
    logic ack;
    int base;
    base = stb_cycles;
    i2c_start();
    send_byte(8'h70, ack);
    send_byte(8'h20, ack);
    send_byte(8'h08, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    i2c_stop();
    chk("R7 early stop discards", stb_cycles - base, 32'd0);
  endtask

  task automatic t_restart();
    logic ack;
    int base;
    base = stb_cycles;
    i2c_start();
    send_byte(8'h70, ack);
    send_byte(8'h20, ack);
    send_byte(8'h04, ack);
    send_byte(8'h99, ack);
    send_byte(8'h88, ack);
    send_byte(8'h77, ack);
    chk("R7 no strobe before restart", stb_cycles - base, 32'd0);
    t_write(16'h1002, 32'h0000_55AA, 2, 2'd1);
    chk("R7 restart yields one strobe", stb_cycles - base, 32'd1);
  endtask

  task automatic t_extra();
    logic ack;
    int base;
    base = stb_cycles;
    i2c_start();
    send_byte(8'h70, ack);
    send_byte(8'h00, ack);
    send_byte(8'h40, ack);
    send_byte(8'h3C, ack);  chk("R8 last byte ack", {31'd0, ack}, 32'd1);
    send_byte(8'hFF, ack);  chk("R8 extra byte nack", {31'd0, ack}, 32'd0);
    i2c_stop();
    chk("R8 single strobe", stb_cycles - base, 32'd1);
    chk("R8 data unchanged by extra", cap_data, 32'h0000_003C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_write(16'h0012, 32'h0000_00A5, 1, 2'd0);
    t_write(16'h1234, 32'h0000_BEEF, 2, 2'd1);
    t_write(16'h2ABC, 32'hDEAD_BEEF, 4, 2'd2);
    t_bad_first(8'h71);
    t_bad_first(8'h72);
    t_write(16'h0001, 32'h0000_005A, 1, 2'd0);
    t_unmapped();
    t_early_stop();
    t_restart();
    t_extra();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule